// File: doc/BRIEF.md
# Attenuated Capture-to-Playback Stereo Mixer

This block adds an attenuated copy of the stereo capture stream into the stereo playback stream, producing one mixed left/right pair per sample period. A byte-wide configuration register holds a mix enable and a 6-bit attenuation code, with 1.5 dB per step. Capture and playback samples arrive on their own valid strobes and are held in per-lane holding registers. A sample-period tick starts each mix. The mix runs on every tick whether or not playback data is flowing.

When capture overruns, arriving capture samples are dropped and the last good capture sample stays in use. When playback underruns, the playback term is either forced to midscale zero or kept at the last valid sample, as the zero-fill select chooses. Samples are 16-bit two's complement. The attenuated term is truncated toward zero, and the final sum saturates rather than wrapping.

Top module: `adm_mixer_top`

## Requirements
- R1: A configuration write stores the byte. Bit 0 is the mix enable, bits 7:2 are the attenuation code, and bit 1 is reserved and always reads 0. After reset the readback is 0x00.
- R2: With the enable at 0, each output lane equals the playback term of that lane, and the capture data has no effect.
- R3: With the enable at 1 and code 0, each output lane equals the playback term plus the held capture sample.
- R4: With the enable at 1 and code k, the capture contribution is the held capture sample times 10^(-1.5k/20), truncated toward zero, to within 2 LSB.
- R5: The sum saturates at +32767 and at -32768 instead of wrapping.
- R6: out_valid is high for exactly one clock, the cycle after each tick. The output samples change only in that cycle.
- R7: A new mixed pair is produced on every tick even when no new playback or capture sample has arrived. The held values are reused.
- R8: A capture sample strobed while cap_ovr is 1 is discarded, and the last capture sample taken before it stays in use.
- R9: If pb_udr is 1 at a tick and zero_fill is 1, the playback term for that period is 0.
- R10: If pb_udr is 1 at a tick and zero_fill is 0, the last valid playback sample is repeated. A playback sample strobed while pb_udr is 1 is discarded.
- R11: The left and right lanes are computed identically and independently.
- R12: After reset, both holding registers and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration readback |
| cap_valid | input | 1 | Capture sample strobe |
| cap_left | input | 16 | Capture left sample |
| cap_right | input | 16 | Capture right sample |
| cap_ovr | input | 1 | Capture overrun flag |
| pb_valid | input | 1 | Playback sample strobe |
| pb_left | input | 16 | Playback left sample |
| pb_right | input | 16 | Playback right sample |
| pb_udr | input | 1 | Playback underrun flag |
| tick | input | 1 | Sample-period tick |
| zero_fill | input | 1 | Midscale-zero select for underrun |
| out_valid | output | 1 | Mixed pair valid |
| out_left | output | 16 | Mixed left sample |
| out_right | output | 16 | Mixed right sample |

## Verification
The properties assume that tick is a one-cycle strobe and that all inputs are known once reset is released. They also assume that a sample strobed on the same edge as a tick is meant for the next period, since the mix reads the holding registers as they stood before that edge. The stimulus keeps to these assumptions. It applies configuration writes and sample strobes in cycles apart from the tick. It raises cap_ovr only together with the capture strobe it should cancel, and it raises pb_udr only during the tick or the playback strobe it covers.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int SMP_W     = 16;
  localparam int ATT_W     = 6;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;

  // 10^(-1.5/20) in Q2.30, one attenuation step
  localparam longint STEP_Q30 = 64'sd903441154;

  // Gain for a given code, as an unsigned fixed-point value with frac bits.
  function automatic longint gain_coef(input int code, input int frac);
    longint acc;
    acc = 64'sd1 <<< 30;
    for (int i = 0; i < code; i++) begin
      acc = (acc * STEP_Q30) >>> 30;
    end
    return acc >>> (30 - frac);
  endfunction
endpackage

// File: rtl/adm_rst_sync.sv
module adm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/adm_cfg_reg.sv
module adm_cfg_reg #(
  parameter int ATT_W = adm_pkg::ATT_W,
  localparam int REG_W = ATT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             mix_en,
  output logic [ATT_W-1:0] att_code
);
  logic             en_q,  en_nxt;
  logic [ATT_W-1:0] att_q, att_nxt;

  always_comb begin
    en_nxt  = en_q;
    att_nxt = att_q;
    if (we) begin
      en_nxt  = wdata[0];
      att_nxt = wdata[REG_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      att_q <= '0;
    end else begin
      en_q  <= en_nxt;
      att_q <= att_nxt;
    end
  end

  assign rdata    = {att_q, 1'b0, en_q};
  assign mix_en   = en_q;
  assign att_code = att_q;

  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == ($past(wdata) & ~(REG_W'(1) << 1))));
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/adm_gain_rom.sv
module adm_gain_rom #(
  parameter int ATT_W     = adm_pkg::ATT_W,
  parameter int COEF_W    = adm_pkg::COEF_W,
  parameter int COEF_FRAC = adm_pkg::COEF_FRAC,
  localparam int DEPTH    = 1 << ATT_W
) (
  input  logic [ATT_W-1:0]  code_i,
  output logic [COEF_W-1:0] coef_o
);
  logic [COEF_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam longint GVAL = adm_pkg::gain_coef(k, COEF_FRAC);
    assign tbl[k] = COEF_W'(GVAL);
  end

  assign coef_o = tbl[code_i];
endmodule

// File: rtl/adm_stream_hold.sv
module adm_stream_hold #(
  parameter int SMP_W   = adm_pkg::SMP_W,
  parameter bit FILL_EN = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    drop,
  input  logic                    fill_sel,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [SMP_W-1:0] term_o
);
  logic signed [SMP_W-1:0] held_q, held_nxt;
  logic                    use_fill;

  always_comb begin
    held_nxt = held_q;
    if (load && !drop) held_nxt = smp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_nxt;
  end

  assign use_fill = FILL_EN && drop && fill_sel;
  assign term_o   = use_fill ? '0 : held_q;

  p_hold_drop_r8_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load || drop) |=> $stable(held_q));
  p_hold_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !drop) |=> (held_q == $past(smp_i)));
endmodule

// File: rtl/adm_mix_lane.sv
module adm_mix_lane #(
  parameter int SMP_W     = adm_pkg::SMP_W,
  parameter int COEF_W    = adm_pkg::COEF_W,
  parameter int COEF_FRAC = adm_pkg::COEF_FRAC,
  localparam int PW       = SMP_W + COEF_W + 1
) (
  input  logic                    mix_en,
  input  logic [COEF_W-1:0]       coef,
  input  logic signed [SMP_W-1:0] cap_term,
  input  logic signed [SMP_W-1:0] pb_term,
  output logic signed [SMP_W-1:0] mix_o
);
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (SMP_W-1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] prod, bias, scaled, contrib, sum;

  always_comb begin
    prod = cap_term * $signed({1'b0, coef});
    bias = '0;
    bias[COEF_FRAC-1:0] = {COEF_FRAC{prod[PW-1]}};
    scaled  = (prod + bias) >>> COEF_FRAC;
    contrib = mix_en ? scaled : '0;
    sum     = contrib + PW'(pb_term);
    if (sum > MAXV)      mix_o = MAXV[SMP_W-1:0];
    else if (sum < MINV) mix_o = MINV[SMP_W-1:0];
    else                 mix_o = sum[SMP_W-1:0];
  end
endmodule

// File: rtl/adm_mixer_top.sv
module adm_mixer_top #(
  parameter int SMP_W     = adm_pkg::SMP_W,
  parameter int ATT_W     = adm_pkg::ATT_W,
  parameter int COEF_W    = adm_pkg::COEF_W,
  parameter int COEF_FRAC = adm_pkg::COEF_FRAC,
  localparam int REG_W    = ATT_W + 2,
  localparam int LANES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             cap_valid,
  input  logic [SMP_W-1:0] cap_left,
  input  logic [SMP_W-1:0] cap_right,
  input  logic             cap_ovr,
  input  logic             pb_valid,
  input  logic [SMP_W-1:0] pb_left,
  input  logic [SMP_W-1:0] pb_right,
  input  logic             pb_udr,
  input  logic             tick,
  input  logic             zero_fill,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_left,
  output logic [SMP_W-1:0] out_right
);
  logic              srst_n;
  logic              mix_en;
  logic [ATT_W-1:0]  att_code;
  logic [COEF_W-1:0] coef;

  logic signed [SMP_W-1:0] cap_in  [LANES];
  logic signed [SMP_W-1:0] pb_in   [LANES];
  logic signed [SMP_W-1:0] cap_term[LANES];
  logic signed [SMP_W-1:0] pb_term [LANES];
  logic signed [SMP_W-1:0] mix     [LANES];
  logic signed [SMP_W-1:0] out_q   [LANES];
  logic signed [SMP_W-1:0] out_nxt [LANES];
  logic                    vld_q, vld_nxt;

  assign cap_in[0] = cap_left;
  assign cap_in[1] = cap_right;
  assign pb_in[0]  = pb_left;
  assign pb_in[1]  = pb_right;

  adm_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  adm_cfg_reg #(.ATT_W(ATT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (srst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .mix_en   (mix_en),
    .att_code (att_code)
  );

  adm_gain_rom #(.ATT_W(ATT_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_gain (
    .code_i (att_code),
    .coef_o (coef)
  );

  for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
    adm_stream_hold #(.SMP_W(SMP_W), .FILL_EN(1'b0)) u_cap_hold (
      .clk      (clk),
      .rst_n    (srst_n),
      .load     (cap_valid),
      .drop     (cap_ovr),
      .fill_sel (1'b0),
      .smp_i    (cap_in[ch]),
      .term_o   (cap_term[ch])
    );

    adm_stream_hold #(.SMP_W(SMP_W), .FILL_EN(1'b1)) u_pb_hold (
      .clk      (clk),
      .rst_n    (srst_n),
      .load     (pb_valid),
      .drop     (pb_udr),
      .fill_sel (zero_fill),
      .smp_i    (pb_in[ch]),
      .term_o   (pb_term[ch])
    );

    adm_mix_lane #(.SMP_W(SMP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_lane (
      .mix_en   (mix_en),
      .coef     (coef),
      .cap_term (cap_term[ch]),
      .pb_term  (pb_term[ch]),
      .mix_o    (mix[ch])
    );

    p_mute_r2: assert property (@(posedge clk) disable iff (!srst_n)
      (tick && !mix_en) |=> (out_q[ch] == $past(pb_term[ch])));
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!srst_n)
      (tick && !pb_term[ch][SMP_W-1] && !cap_term[ch][SMP_W-1]) |=> !out_q[ch][SMP_W-1]);
    p_out_stable_r6: assert property (@(posedge clk) disable iff (!srst_n)
      !tick |=> $stable(out_q[ch]));
  end

  always_comb begin
    vld_nxt = tick;
    for (int ch = 0; ch < LANES; ch++) begin
      out_nxt[ch] = tick ? mix[ch] : out_q[ch];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
      for (int ch = 0; ch < LANES; ch++) out_q[ch] <= '0;
    end else begin
      vld_q <= vld_nxt;
      for (int ch = 0; ch < LANES; ch++) out_q[ch] <= out_nxt[ch];
    end
  end

  assign out_valid = vld_q;
  assign out_left  = out_q[0];
  assign out_right = out_q[1];

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!srst_n)
    tick |=> out_valid);
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !tick |=> !out_valid);
endmodule

// File: tb/adm_mixer_top_tb.sv
`timescale 1ns/1ps
module adm_mixer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        cap_valid, cap_ovr, pb_valid, pb_udr, tick, zero_fill;
  logic [15:0] cap_left, cap_right, pb_left, pb_right;
  logic        out_valid;
  logic [15:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adm_mixer_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cap_valid(cap_valid), .cap_left(cap_left), .cap_right(cap_right), .cap_ovr(cap_ovr),
    .pb_valid(pb_valid), .pb_left(pb_left), .pb_right(pb_right), .pb_udr(pb_udr),
    .tick(tick), .zero_fill(zero_fill),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  typedef struct packed {
    logic               en;
    logic [5:0]         att;
    logic signed [15:0] cl;
    logic signed [15:0] cr;
    logic signed [15:0] pl;
    logic signed [15:0] pr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'd0,  16'sd1000,   -16'sd1000,  16'sd500,    -16'sd500},
    '{1'b1, 6'd0,  16'sd1000,   -16'sd1000,  16'sd500,    -16'sd500},
    '{1'b1, 6'd4,  16'sd16384,  -16'sd16384, 16'sd0,      16'sd0},
    '{1'b1, 6'd20, 16'sd30000,  -16'sd30000, 16'sd100,    16'sd100},
    '{1'b1, 6'd0,  16'sd30000,  -16'sd30000, 16'sd10000,  -16'sd10000},
    '{1'b1, 6'd63, 16'sd32767,  -16'sd32768, 16'sd7,      -16'sd7},
    '{1'b1, 6'd1,  -16'sd32768, 16'sd12345,  16'sd32767,  -16'sd32768},
    '{1'b0, 6'd10, 16'sd20000,  16'sd20000,  -16'sd32768, 16'sd32767}
  };

  function automatic int model(input bit en, input int att, input int cap, input int pb);
    real g;
    int  c;
    int  s;
    c = 0;
    if (en) begin
      g = $pow(10.0, -0.075 * att);
      c = $rtoi($itor(cap) * g);
    end
    s = pb + c;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_cap(input logic [15:0] l, input logic [15:0] r, input logic ovr);
    @(negedge clk);
    cap_valid = 1'b1; cap_left = l; cap_right = r; cap_ovr = ovr;
    @(negedge clk);
    cap_valid = 1'b0; cap_ovr = 1'b0;
  endtask

  task automatic put_pb(input logic [15:0] l, input logic [15:0] r, input logic udr);
    @(negedge clk);
    pb_valid = 1'b1; pb_left = l; pb_right = r; pb_udr = udr;
    @(negedge clk);
    pb_valid = 1'b0; pb_udr = 1'b0;
  endtask

  // Tick for one cycle; on return out_valid should be high with the new pair.
  task automatic do_tick(input logic udr, input logic zf);
    @(negedge clk);
    tick = 1'b1; pb_udr = udr; zero_fill = zf;
    @(negedge clk);
    tick = 1'b0; pb_udr = 1'b0; zero_fill = 1'b0;
  endtask

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int l0, r0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cap_valid = 1'b0; cap_ovr = 1'b0; cap_left = '0; cap_right = '0;
    pb_valid = 1'b0; pb_udr = 1'b0; pb_left = '0; pb_right = '0;
    tick = 1'b0; zero_fill = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    check("R1 reset readback", int'(cfg_rdata), 0, 0);
    check("R6 no valid before tick", int'(out_valid), 0, 0);
    check("R12 reset out_left", s16(out_left), 0, 0);
    do_tick(1'b0, 1'b0);
    check("R6 valid after tick", int'(out_valid), 1, 0);
    check("R12 held left zero", s16(out_left), 0, 0);
    check("R12 held right zero", s16(out_right), 0, 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      int tol;
      tol = (VECS[i].en && VECS[i].att != 0) ? 2 : 0;
      wr_cfg({VECS[i].att, 1'b0, VECS[i].en});
      put_cap(VECS[i].cl, VECS[i].cr, 1'b0);
      put_pb(VECS[i].pl, VECS[i].pr, 1'b0);
      do_tick(1'b0, 1'b0);
      check("R2 R3 R4 R5 R11 vector left", s16(out_left),
            model(VECS[i].en, VECS[i].att, VECS[i].cl, VECS[i].pl), tol);
      check("R2 R3 R4 R5 R11 vector right", s16(out_right),
            model(VECS[i].en, VECS[i].att, VECS[i].cr, VECS[i].pr), tol);
    end

    // R1 reserved bit
    wr_cfg(8'hFF);
    check("R1 reserved bit reads zero", int'(cfg_rdata), 'hFD, 0);

    // R6 single-cycle valid and stable output
    wr_cfg(8'h01);
    put_cap(16'd300, 16'd300, 1'b0);
    put_pb(16'd20, 16'd20, 1'b0);
    do_tick(1'b0, 1'b0);
    l0 = s16(out_left);
    check("R6 mixed value", l0, 320, 0);
    @(negedge clk);
    check("R6 valid drops", int'(out_valid), 0, 0);
    put_cap(16'd5000, 16'd5000, 1'b0);
    check("R6 output holds between ticks", s16(out_left), 320, 0);

    // R7 repeated ticks without new samples
    do_tick(1'b0, 1'b0);
    l0 = s16(out_left);
    do_tick(1'b0, 1'b0);
    check("R7 repeat tick valid", int'(out_valid), 1, 0);
    check("R7 repeat tick value", s16(out_left), l0, 0);

    // R8 overrun keeps last capture
    put_cap(16'd100, -16'sd100, 1'b0);
    put_pb(16'd0, 16'd0, 1'b0);
    put_cap(16'd9000, 16'd9000, 1'b1);
    do_tick(1'b0, 1'b0);
    check("R8 overrun left", s16(out_left), 100, 0);
    check("R8 overrun right", s16(out_right), -100, 0);

    // R9 underrun with zero fill
    wr_cfg(8'h00);
    put_pb(16'd400, -16'sd400, 1'b0);
    do_tick(1'b1, 1'b1);
    check("R9 zero fill left", s16(out_left), 0, 0);
    check("R9 zero fill right", s16(out_right), 0, 0);

    // R10 underrun repeats last valid, strobe during underrun ignored
    put_pb(16'd777, 16'd777, 1'b1);
    do_tick(1'b1, 1'b0);
    check("R10 repeat left", s16(out_left), 400, 0);
    check("R10 repeat right", s16(out_right), -400, 0);
    do_tick(1'b0, 1'b0);
    check("R10 strobe ignored", s16(out_left), 400, 0);

    // R12 reset clears holding registers
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset after run", int'(cfg_rdata), 0, 0);
    do_tick(1'b0, 1'b0);
    r0 = s16(out_right);
    check("R12 reset clears playback", r0, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule